// File: doc/BRIEF.md
# Flash Command Sequencer with Status Polling

This block is the command front end of a small NOR-style flash model. A host reaches it through a synchronous bus. A write cycle is a clock edge with `sel` and `wr_en` high, and a read cycle is a clock edge with `sel` and `rd_en` high. A decoder state machine turns series of write cycles into commands. It recognises a three-write unlock prefix followed by a command byte, a second unlock pair for sector erase, and a bypass mode in which a program needs only two writes. A valid program or erase starts an operation engine. The engine runs for a parameterised number of cycles against a register-based array and then commits the result.

While the engine is busy, `ready` is low and every read returns a status byte instead of array data. In that byte, bit 7 is the complement of bit 7 of the value being written, and bit 6 flips on each status read. A host can therefore find completion by watching `ready`, by waiting for bit 7 to show the true data, or by waiting for bit 6 to stop flipping. One mask bit per sector blocks program and erase on that sector. A low-supply input blocks all writes.

Decoder states: `CS_READ` (array read), `CS_UNL1` (first unlock byte seen), `CS_UNL2` (unlock pair seen, waiting for the command byte), `CS_PROG_ADDR` (waiting for the program address and data), `CS_ERS_SETUP` (erase armed), `CS_ERS_UNL1` and `CS_ERS_UNL2` (second unlock pair), `CS_BYP` (bypass idle), `CS_BYP_PROG` (bypass program, waiting for the address and data), `CS_BYP_EXIT` (first exit byte seen).

Decoder transitions:
- `CS_READ` to `CS_UNL1` on 0xAA@0x555.
- `CS_UNL1` to `CS_UNL2` on 0x55@0x2AA.
- `CS_UNL2` to `CS_PROG_ADDR` on 0xA0, to `CS_ERS_SETUP` on 0x80, and to `CS_BYP` on 0x20.
- `CS_PROG_ADDR` launches a program and returns to `CS_READ`.
- `CS_ERS_SETUP` to `CS_ERS_UNL1` to `CS_ERS_UNL2` on the unlock pair.
- `CS_ERS_UNL2` launches an erase on 0x30 and returns to `CS_READ`.
- `CS_BYP` to `CS_BYP_PROG` on 0xA0 and to `CS_BYP_EXIT` on 0x90.
- `CS_BYP_PROG` launches a program and returns to `CS_BYP`.
- `CS_BYP_EXIT` to `CS_READ` on 0x00.
- Any other write in a read-mode sequence state returns to `CS_READ`. Any other write in a bypass state returns to `CS_BYP`.

Engine states: `OP_IDLE` leads to `OP_PROG`, which runs PROG_CYC cycles. `OP_IDLE` also leads to `OP_PREP` (one cycle, clears the sector to zeros), then `OP_ERASE` (ERASE_CYC cycles), then `OP_FILL` (one cycle, sets the sector to ones), and back to `OP_IDLE`.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by data D at address A, program location A to old AND D, so programming only clears bits.
- R2: The writes 0xAA@0x555, 0x55@0x2AA and 0x20@0x555 enter bypass mode. In bypass mode, 0xA0 followed by D@A programs. The write 0x90 followed by 0x00 leaves bypass mode, after which 0xA0 followed by D@A has no effect.
- R3: While busy, every read returns bit 7 = NOT bit 7 of the target data (the target is 0xFF for erase), bit 6 = a flag that starts at 0 and flips after each read, and bits 5:0 = 0. Once the operation is done, reads return array data.
- R4: `ready` falls on the edge that accepts the last write of a valid command. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC+2 cycles for an erase.
- R5: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30 at any address in sector S leave every location of S at 0xFF. Other sectors are unchanged. The sector index is addr[ARR_AW-1:SEC_AW].
- R6: When `prot_mask[S]` is 1, a program or erase that targets sector S is ignored: `ready` stays high and the array is unchanged.
- R7: While `low_vdd` is 1, write cycles are ignored, and the decoder keeps its sequence position across them.
- R8: An unexpected write in the middle of a sequence, including 0xF0, returns the decoder to array read. Writes in array read other than 0xAA@0x555 have no effect.
- R9: A low `rst_n` returns the decoder to array read, aborts any operation, drives `ready` high and sets the array to all ones.
- R10: Write cycles while `ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus select for this cycle |
| wr_en | input | 1 | Write cycle qualifier |
| rd_en | input | 1 | Read cycle qualifier |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Array data or status byte (combinational) |
| ready | output | 1 | High when idle, low while an operation runs |
| low_vdd | input | 1 | Low-supply indicator, blocks writes |
| prot_mask | input | 2^(ARR_AW-SEC_AW) | One protect bit per sector |

## Verification
A decoder stuck in the wrong state is only seen when a command is accepted or lost. It shows up at the first `ready` edge, or at the first array read after the sequence that should or should not have programmed. An engine with a miscounted timer moves the `ready` rise by one or more cycles, so the bench counts busy cycles exactly. A fault in the status generator shows on the very next read during busy, through a bit 6 that does not flip or a bit 7 that has the wrong polarity.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        CS_READ,
        CS_UNL1,
        CS_UNL2,
        CS_PROG_ADDR,
        CS_ERS_SETUP,
        CS_ERS_UNL1,
        CS_ERS_UNL2,
        CS_BYP,
        CS_BYP_PROG,
        CS_BYP_EXIT
    } cmd_state_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PROG,
        OP_PREP,
        OP_ERASE,
        OP_FILL
    } op_state_t;

    localparam logic [DATA_W-1:0] K_KEY_A     = 8'hAA;
    localparam logic [DATA_W-1:0] K_KEY_B     = 8'h55;
    localparam logic [DATA_W-1:0] K_PROG      = 8'hA0;
    localparam logic [DATA_W-1:0] K_ERS_ARM   = 8'h80;
    localparam logic [DATA_W-1:0] K_ERS_GO    = 8'h30;
    localparam logic [DATA_W-1:0] K_BYP_ENTER = 8'h20;
    localparam logic [DATA_W-1:0] K_BYP_LEAVE = 8'h90;
    localparam logic [DATA_W-1:0] K_BYP_DONE  = 8'h00;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              go_prog,
    output logic              go_erase,
    output cmd_state_t        state_o
);

    localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(12'h2AA);

    cmd_state_t state, nxt;

    logic key_a, key_b;
    assign key_a = (addr == A_FIRST)  && (wdata == K_KEY_A);
    assign key_b = (addr == A_SECOND) && (wdata == K_KEY_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_READ;
        else        state <= nxt;
    end

    // next state and launch strobes
    always_comb begin
        nxt      = state;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        if (wr_stb) begin
            unique case (state)
                CS_READ:      nxt = key_a ? CS_UNL1 : CS_READ;
                CS_UNL1:      nxt = key_b ? CS_UNL2 : CS_READ;
                CS_UNL2: begin
                    nxt = CS_READ;
                    if (addr == A_FIRST) begin
                        if (wdata == K_PROG)           nxt = CS_PROG_ADDR;
                        else if (wdata == K_ERS_ARM)   nxt = CS_ERS_SETUP;
                        else if (wdata == K_BYP_ENTER) nxt = CS_BYP;
                    end
                end
                CS_PROG_ADDR: begin
                    go_prog = 1'b1;
                    nxt     = CS_READ;
                end
                CS_ERS_SETUP: nxt = key_a ? CS_ERS_UNL1 : CS_READ;
                CS_ERS_UNL1:  nxt = key_b ? CS_ERS_UNL2 : CS_READ;
                CS_ERS_UNL2: begin
                    go_erase = (wdata == K_ERS_GO);
                    nxt      = CS_READ;
                end
                CS_BYP: begin
                    if (wdata == K_PROG)           nxt = CS_BYP_PROG;
                    else if (wdata == K_BYP_LEAVE) nxt = CS_BYP_EXIT;
                    else                           nxt = CS_BYP;
                end
                CS_BYP_PROG: begin
                    go_prog = 1'b1;
                    nxt     = CS_BYP;
                end
                CS_BYP_EXIT:  nxt = (wdata == K_BYP_DONE) ? CS_READ : CS_BYP;
                default:      nxt = CS_READ;
            endcase
        end
    end

    assign state_o = state;

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_seq_pkg::*;
#(
    parameter int ARR_AW    = 8,
    parameter int SEC_AW    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                go_prog,
    input  logic                                go_erase,
    input  logic [ARR_AW-1:0]                   op_addr,
    input  logic [DATA_W-1:0]                   op_data,
    input  logic [(1<<(ARR_AW-SEC_AW))-1:0]     prot_mask,
    input  logic [ARR_AW-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic                                busy,
    output logic                                tgt7
);

    localparam int DEPTH    = 1 << ARR_AW;
    localparam int SEC_SIZE = 1 << SEC_AW;
    localparam int SEC_W    = ARR_AW - SEC_AW;
    localparam int CNT_MAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    op_state_t            st, nxt;
    logic [CNT_W-1:0]     cnt, cnt_n;
    logic [ARR_AW-1:0]    lat_addr;
    logic [DATA_W-1:0]    lat_data;
    logic [DATA_W-1:0]    mem [DEPTH];

    logic [SEC_W-1:0]     req_sec, lat_sec;
    logic                 allowed, launch;

    assign req_sec = op_addr[ARR_AW-1:SEC_AW];
    assign lat_sec = lat_addr[ARR_AW-1:SEC_AW];
    assign allowed = !prot_mask[req_sec];
    assign launch  = (st == OP_IDLE) && (go_prog || go_erase) && allowed;

    // state register with timer and operand latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= OP_IDLE;
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '1;
        end else begin
            st  <= nxt;
            cnt <= cnt_n;
            if (launch) begin
                lat_addr <= op_addr;
                lat_data <= go_prog ? op_data : '1;
            end
        end
    end

    // next state
    always_comb begin
        nxt   = st;
        cnt_n = cnt;
        unique case (st)
            OP_IDLE: begin
                if (go_prog && allowed) begin
                    nxt   = OP_PROG;
                    cnt_n = CNT_W'(PROG_CYC - 1);
                end else if (go_erase && allowed) begin
                    nxt = OP_PREP;
                end
            end
            OP_PROG: begin
                if (cnt == '0) nxt = OP_IDLE;
                else           cnt_n = cnt - CNT_W'(1);
            end
            OP_PREP: begin
                nxt   = OP_ERASE;
                cnt_n = CNT_W'(ERASE_CYC - 1);
            end
            OP_ERASE: begin
                if (cnt == '0) nxt = OP_FILL;
                else           cnt_n = cnt - CNT_W'(1);
            end
            OP_FILL: nxt = OP_IDLE;
            default: nxt = OP_IDLE;
        endcase
    end

    // array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            unique case (st)
                OP_PROG: if (cnt == '0) mem[lat_addr] <= mem[lat_addr] & lat_data;
                OP_PREP: for (int i = 0; i < SEC_SIZE; i++) mem[{lat_sec, SEC_AW'(i)}] <= '0;
                OP_FILL: for (int i = 0; i < SEC_SIZE; i++) mem[{lat_sec, SEC_AW'(i)}] <= '1;
                default: ;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (st != OP_IDLE);
    assign tgt7    = lat_data[DATA_W-1];

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_stb,
    input  logic              tgt7,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata
);

    logic tog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tog <= 1'b0;
        else if (!busy)          tog <= 1'b0;
        else if (rd_stb)         tog <= ~tog;
    end

    always_comb begin
        if (busy) rdata = {~tgt7, tog, {(DATA_W-2){1'b0}}};
        else      rdata = arr_data;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int ARR_AW    = 8,
    parameter int SEC_AW    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [7:0]                      wdata,
    output logic [7:0]                      rdata,
    output logic                            ready,
    input  logic                            low_vdd,
    input  logic [(1<<(ARR_AW-SEC_AW))-1:0] prot_mask
);

    logic       busy, wr_stb, rd_stb, go_prog, go_erase, tgt7;
    logic [7:0] arr_data;
    cmd_state_t cmd_st;

    assign wr_stb = sel && wr_en && !low_vdd && !busy;
    assign rd_stb = sel && rd_en && !wr_en;

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .addr     (addr),
        .wdata    (wdata),
        .go_prog  (go_prog),
        .go_erase (go_erase),
        .state_o  (cmd_st)
    );

    flash_op_engine #(
        .ARR_AW    (ARR_AW),
        .SEC_AW    (SEC_AW),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .go_erase  (go_erase),
        .op_addr   (addr[ARR_AW-1:0]),
        .op_data   (wdata),
        .prot_mask (prot_mask),
        .rd_addr   (addr[ARR_AW-1:0]),
        .rd_data   (arr_data),
        .busy      (busy),
        .tgt7      (tgt7)
    );

    flash_status_gen u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_stb   (rd_stb),
        .tgt7     (tgt7),
        .arr_data (arr_data),
        .rdata    (rdata)
    );

    assign ready = !busy;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int ERASE_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic       low_vdd,
    input logic       ready,
    input logic [7:0] rdata,
    input cmd_state_t cmd_st
);

    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_run <= '0;
        else if (ready) busy_run <= '0;
        else            busy_run <= busy_run + 16'd1;
    end

    assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(ERASE_CYC + 2));

    assert_busy_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(sel && wr_en && !low_vdd));

    assert_poll_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && sel && rd_en && !wr_en) ##1 !ready |-> rdata[6] != $past(rdata[6]));

    assert_poll_bit7_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> rdata[7] == $past(rdata[7]));

    assert_lowvdd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && low_vdd) |=> $stable(cmd_st));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(cmd_st));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .low_vdd (low_vdd),
    .ready   (ready),
    .rdata   (rdata),
    .cmd_st  (cmd_st)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int CLK_PER   = 10;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 16;

    // vector: op[28:27] (0 write, 1 read-check, 2 wait ready), addr[26:16], data[15:8], exp[7:0]
    localparam int NVEC = 44;
    localparam logic [28:0] VEC [NVEC] = '{
        // R1 program then AND-only reprogram
        {2'd0, 11'h555, 8'hAA, 8'h00}, {2'd0, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 11'h555, 8'hA0, 8'h00}, {2'd0, 11'h010, 8'h5A, 8'h00},
        {2'd2, 11'h000, 8'h00, 8'h00}, {2'd1, 11'h010, 8'h00, 8'h5A},
        {2'd0, 11'h555, 8'hAA, 8'h00}, {2'd0, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 11'h555, 8'hA0, 8'h00}, {2'd0, 11'h010, 8'hF0, 8'h00},
        {2'd2, 11'h000, 8'h00, 8'h00}, {2'd1, 11'h010, 8'h00, 8'h50},
        // R2 bypass enter, two programs, exit, then short program ignored
        {2'd0, 11'h555, 8'hAA, 8'h00}, {2'd0, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 11'h555, 8'h20, 8'h00}, {2'd0, 11'h000, 8'hA0, 8'h00},
        {2'd0, 11'h021, 8'h33, 8'h00}, {2'd2, 11'h000, 8'h00, 8'h00},
        {2'd1, 11'h021, 8'h00, 8'h33}, {2'd0, 11'h07F, 8'hA0, 8'h00},
        {2'd0, 11'h022, 8'h0F, 8'h00}, {2'd2, 11'h000, 8'h00, 8'h00},
        {2'd1, 11'h022, 8'h00, 8'h0F}, {2'd0, 11'h000, 8'h90, 8'h00},
        {2'd0, 11'h000, 8'h00, 8'h00}, {2'd0, 11'h555, 8'hA0, 8'h00},
        {2'd0, 11'h023, 8'h00, 8'h00}, {2'd1, 11'h023, 8'h00, 8'hFF},
        // R8 broken unlock, 0xF0 mid-sequence, unknown command byte
        {2'd0, 11'h555, 8'hAA, 8'h00}, {2'd0, 11'h2AA, 8'h12, 8'h00},
        {2'd0, 11'h2AA, 8'h55, 8'h00}, {2'd0, 11'h555, 8'hA0, 8'h00},
        {2'd0, 11'h024, 8'h00, 8'h00}, {2'd1, 11'h024, 8'h00, 8'hFF},
        {2'd0, 11'h555, 8'hAA, 8'h00}, {2'd0, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 11'h555, 8'hF0, 8'h00}, {2'd0, 11'h025, 8'h00, 8'h00},
        {2'd1, 11'h025, 8'h00, 8'hFF}, {2'd0, 11'h555, 8'hAA, 8'h00},
        {2'd0, 11'h2AA, 8'h55, 8'h00}, {2'd0, 11'h555, 8'h77, 8'h00},
        {2'd0, 11'h026, 8'h00, 8'h00}, {2'd1, 11'h026, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, low_vdd = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;
    logic [3:0]  prot_mask = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PER/2) clk = ~clk;

    flash_cmd_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
        .low_vdd(low_vdd), .prot_mask(prot_mask)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [10:0] a, output logic [7:0] d);
        sel = 1'b1; rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic unlock3(input logic [7:0] c);
        do_wr(11'h555, 8'hAA);
        do_wr(11'h2AA, 8'h55);
        do_wr(11'h555, c);
    endtask

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        chk("R9 ready during reset", 16'(ready), 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        do_rd(11'h000, d);
        chk("R9 array erased after reset", 16'(d), 16'h00FF);

        // table walk: R1 R2 R8
        for (int i = 0; i < NVEC; i++) begin
            unique case (VEC[i][28:27])
                2'd0: do_wr(VEC[i][26:16], VEC[i][15:8]);
                2'd1: begin
                    do_rd(VEC[i][26:16], d);
                    chk($sformatf("R1/R2/R8 vector %0d", i), 16'(d), 16'(VEC[i][7:0]));
                end
                default: wait_rdy(n);
            endcase
        end

        // R3 polling and R4 program timing
        unlock3(8'hA0);
        do_wr(11'h040, 8'h3C);
        do_rd(11'h040, d);
        chk("R3 first status read", 16'(d), 16'h0080);
        do_rd(11'h040, d);
        chk("R3 second status read", 16'(d), 16'h00C0);
        wait_rdy(n);
        do_rd(11'h040, d);
        chk("R3 data after completion", 16'(d), 16'h003C);
        do_rd(11'h040, d);
        chk("R3 no toggle after completion", 16'(d), 16'h003C);

        unlock3(8'hA0);
        do_wr(11'h041, 8'h00);
        chk("R4 ready falls on program", 16'(ready), 16'd0);
        wait_rdy(n);
        chk("R4 program busy cycles", 16'(n), 16'(PROG_CYC));

        // R5 sector erase of sector 1
        unlock3(8'h80);
        do_wr(11'h555, 8'hAA);
        do_wr(11'h2AA, 8'h55);
        do_wr(11'h045, 8'h30);
        do_rd(11'h045, d);
        chk("R3 erase status read", 16'(d), 16'h0000);
        wait_rdy(n);
        chk("R4 erase busy cycles", 16'(n), 16'(ERASE_CYC + 1));
        do_rd(11'h041, d);
        chk("R5 erased location", 16'(d), 16'h00FF);
        do_rd(11'h040, d);
        chk("R5 erased location 2", 16'(d), 16'h00FF);
        do_rd(11'h010, d);
        chk("R5 other sector kept", 16'(d), 16'h0050);

        // R6 protection
        unlock3(8'hA0);
        do_wr(11'h090, 8'h11);
        wait_rdy(n);
        prot_mask = 4'b0100;
        unlock3(8'h80);
        do_wr(11'h555, 8'hAA);
        do_wr(11'h2AA, 8'h55);
        do_wr(11'h080, 8'h30);
        chk("R6 protected erase no busy", 16'(ready), 16'd1);
        do_rd(11'h090, d);
        chk("R6 protected erase no change", 16'(d), 16'h0011);
        unlock3(8'hA0);
        do_wr(11'h091, 8'h00);
        chk("R6 protected program no busy", 16'(ready), 16'd1);
        do_rd(11'h091, d);
        chk("R6 protected program no change", 16'(d), 16'h00FF);
        prot_mask = 4'b0000;

        // R7 low supply
        low_vdd = 1'b1;
        unlock3(8'hA0);
        do_wr(11'h030, 8'h00);
        chk("R7 inhibited program no busy", 16'(ready), 16'd1);
        low_vdd = 1'b0;
        do_rd(11'h030, d);
        chk("R7 inhibited program no change", 16'(d), 16'h00FF);
        do_wr(11'h555, 8'hAA);
        low_vdd = 1'b1;
        do_wr(11'h2AA, 8'h12);
        low_vdd = 1'b0;
        do_wr(11'h2AA, 8'h55);
        do_wr(11'h555, 8'hA0);
        do_wr(11'h031, 8'h00);
        wait_rdy(n);
        do_rd(11'h031, d);
        chk("R7 sequence position kept", 16'(d), 16'h0000);

        // R10 writes while busy ignored
        unlock3(8'hA0);
        do_wr(11'h032, 8'h00);
        do_wr(11'h555, 8'hAA);
        wait_rdy(n);
        do_wr(11'h2AA, 8'h55);
        do_wr(11'h555, 8'hA0);
        do_wr(11'h033, 8'h00);
        do_rd(11'h033, d);
        chk("R10 write during busy ignored", 16'(d), 16'h00FF);
        do_rd(11'h032, d);
        chk("R10 running program completes", 16'(d), 16'h0000);

        // R9 reset mid-operation and mid-sequence
        unlock3(8'hA0);
        do_wr(11'h034, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset aborts busy", 16'(ready), 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        do_rd(11'h010, d);
        chk("R9 array ones after reset", 16'(d), 16'h00FF);
        do_rd(11'h034, d);
        chk("R9 aborted program lost", 16'(d), 16'h00FF);
        do_wr(11'h555, 8'hAA);
        do_wr(11'h2AA, 8'h55);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_wr(11'h555, 8'hA0);
        do_wr(11'h035, 8'h00);
        do_rd(11'h035, d);
        chk("R9 sequence cleared by reset", 16'(d), 16'h00FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule